// File: doc/BRIEF.md
# FPGA Power-Cycle Recovery Supervisor

This block is a small supervisor that lives outside the main FPGA and owns that device's supply switch and its boot-image choice. After reset it holds the FPGA unpowered until both the supply-health input and the temperature-health input report good. It then powers the FPGA from the currently selected configuration memory. A fixed startup grace window covers the configuration load. After that window the supervisor expects the FPGA's heartbeat line to change level regularly.

When the heartbeat stays quiet for too long, or when the FPGA raises its restart request, the supervisor removes power. In the same cycle it swaps the configuration memory select to the redundant copy and adds one to a saturating recovery counter. It keeps power off for a minimum off time and then powers up again. If supply or temperature health is lost at any moment, power is removed and the supervisor goes back to waiting. This path changes neither the memory select nor the counter.

All four inputs are asynchronous and pass through a synchronizer. Times are counted in ticks, and one tick is `TICK_DIV` clock cycles.

Top module: `pwr_recovery_sup`

## Requirements
- R1: `fpga_pwr_en_o` stays low while `pwr_ok_i` or `temp_ok_i` is low. It rises only once both have been high through the synchronizer.
- R2: After reset `fpga_pwr_en_o` is 0, `mem_sel_o` is 0 (primary copy) and `recov_cnt_o` is 0.
- R3: While the heartbeat changes level at intervals shorter than `HB_TIMEOUT` ticks, power stays on and no recovery happens. The heartbeat is not judged during the first `GRACE_TICKS` ticks after power-on.
- R4: If the heartbeat makes no level change after power-on, power is held on for exactly `GRACE_TICKS + HB_TIMEOUT` ticks and is then removed.
- R5: After a recovery power-off, power stays off for exactly `OFF_TICKS` ticks and is then reapplied, provided health is still good.
- R6: `mem_sel_o` is inverted in the cycle in which a recovery removes power. This holds for both heartbeat loss and requests. It never changes while power is on.
- R7: A rising edge of `req_i`, seen while powered, causes exactly one recovery cycle however long the line stays high. An edge that arrives while power is off is ignored. A request and a heartbeat expiry in the same cycle give a single recovery.
- R8: `recov_cnt_o` rises by one per recovery cycle and stops at 2^`CNT_W`-1.
- R9: Loss of `pwr_ok_i` or `temp_ok_i` in any state removes power one cycle after the synchronized loss. It leaves `mem_sel_o` and `recov_cnt_o` unchanged and returns to waiting, and power comes back once health is good again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_i | input | 1 | Heartbeat line from the FPGA (asynchronous) |
| req_i | input | 1 | Power-cycle request from the FPGA (asynchronous, edge-sensitive) |
| pwr_ok_i | input | 1 | Supply health, high when good (asynchronous) |
| temp_ok_i | input | 1 | Temperature health, high when good (asynchronous) |
| fpga_pwr_en_o | output | 1 | FPGA supply enable |
| mem_sel_o | output | 1 | Configuration memory select, 0 primary and 1 redundant |
| recov_cnt_o | output | CNT_W | Saturating count of recovery cycles |

## Verification
A software restart request and a heartbeat expiry can trigger a recovery in the same cycle. The bench provokes this collision by letting the heartbeat die and then raising the request at seven offsets, spread from three cycles before to three cycles after the computed expiry cycle. Every offset must produce exactly one power-off, one memory-select inversion and an off time of exactly `OFF_TICKS`. No second cycle may follow. A health loss that lands in the same window must win over both triggers and leave the select and the counter untouched.

// File: rtl/pwr_recovery_pkg.sv
package pwr_recovery_pkg;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_GRACE = 2'd1,
      ST_RUN   = 2'd2,
      ST_OFF   = 2'd3
   } sup_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/prs_edge_det.sv
module prs_edge_det #(
   parameter bit ANY_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic evt_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   if (ANY_EDGE) begin : g_any
      assign evt_o = lvl_i ^ prev_q;
   end else begin : g_rise
      assign evt_o = lvl_i & ~prev_q;
   end
endmodule

// File: rtl/prs_tick_gen.sv
module prs_tick_gen #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (DIV == 1) begin : g_every
      logic on_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) on_q <= 1'b0;
         else        on_q <= 1'b1;
      end
      assign tick_o = on_q;
   end else begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] div_q;
      logic          tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q  <= '0;
            tick_q <= 1'b0;
         end else if (div_q == DW'(DIV - 1)) begin
            div_q  <= '0;
            tick_q <= 1'b1;
         end else begin
            div_q  <= div_q + 1'b1;
            tick_q <= 1'b0;
         end
      end
      assign tick_o = tick_q;
   end
endmodule

// File: rtl/prs_hb_watch.sv
module prs_hb_watch #(
   parameter int TIMEOUT = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic tick_i,
   input  logic edge_i,
   output logic lost_o
);
   localparam int CW = $clog2(TIMEOUT);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   logic [CW-1:0] quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          quiet_q <= '0;
      else if (!arm_i || edge_i)           quiet_q <= '0;
      else if (tick_i && quiet_q != LAST)  quiet_q <= quiet_q + 1'b1;
   end

   assign lost_o = arm_i & tick_i & ~edge_i & (quiet_q == LAST);
endmodule

// File: rtl/prs_sat_count.sv
module prs_sat_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (inc_i && cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pwr_recovery_sup.sv
module pwr_recovery_sup
   import pwr_recovery_pkg::*;
#(
   parameter int GRACE_TICKS = 1000,
   parameter int HB_TIMEOUT  = 500,
   parameter int OFF_TICKS   = 200,
   parameter int TICK_DIV    = 1000,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hb_i,
   input  logic             req_i,
   input  logic             pwr_ok_i,
   input  logic             temp_ok_i,
   output logic             fpga_pwr_en_o,
   output logic             mem_sel_o,
   output logic [CNT_W-1:0] recov_cnt_o
);
   localparam int MAX_T = max_of(GRACE_TICKS, OFF_TICKS);
   localparam int TMR_W = $clog2(MAX_T + 1);
   localparam logic [TMR_W-1:0] GRACE_LAST = TMR_W'(GRACE_TICKS - 1);
   localparam logic [TMR_W-1:0] OFF_LAST   = TMR_W'(OFF_TICKS - 1);
   localparam logic [TMR_W-1:0] TMR_TOP    = TMR_W'(MAX_T);

   initial begin
      assert (GRACE_TICKS >= 1) else $error("GRACE_TICKS must be at least 1");
      assert (HB_TIMEOUT  >= 2) else $error("HB_TIMEOUT must be at least 2");
      assert (OFF_TICKS   >= 1) else $error("OFF_TICKS must be at least 1");
      assert (TICK_DIV    >= 1) else $error("TICK_DIV must be at least 1");
      assert (CNT_W       >= 1) else $error("CNT_W must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   // synchronized inputs: bit0 heartbeat, bit1 request, bit2 supply, bit3 temperature
   logic [3:0] in_s;
   logic       hb_s, req_s, env_ok_s;
   logic       hb_evt, req_evt, tick, hb_lost;

   prs_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({temp_ok_i, pwr_ok_i, req_i, hb_i}),
      .q_o   (in_s)
   );

   assign hb_s     = in_s[0];
   assign req_s    = in_s[1];
   assign env_ok_s = in_s[2] & in_s[3];

   prs_edge_det #(.ANY_EDGE(1'b1)) u_hb_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (hb_s),
      .evt_o (hb_evt)
   );

   prs_edge_det #(.ANY_EDGE(1'b0)) u_req_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (req_s),
      .evt_o (req_evt)
   );

   prs_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   sup_state_t       state_q, state_d;
   logic [TMR_W-1:0] tmr_q;
   logic             recover;
   logic             pwr_en_q, mem_sel_q;
   logic             grace_done, off_done;

   prs_hb_watch #(.TIMEOUT(HB_TIMEOUT)) u_hb_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (state_q == ST_RUN),
      .tick_i (tick),
      .edge_i (hb_evt),
      .lost_o (hb_lost)
   );

   assign grace_done = tick && (tmr_q == GRACE_LAST);
   assign off_done   = tick && (tmr_q == OFF_LAST);

   always_comb begin
      state_d = state_q;
      recover = 1'b0;
      unique case (state_q)
         ST_WAIT: begin
            if (env_ok_s) state_d = ST_GRACE;
         end
         ST_GRACE: begin
            if (!env_ok_s) begin
               state_d = ST_WAIT;
            end else if (req_evt) begin
               state_d = ST_OFF;
               recover = 1'b1;
            end else if (grace_done) begin
               state_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (!env_ok_s) begin
               state_d = ST_WAIT;
            end else if (req_evt || hb_lost) begin
               state_d = ST_OFF;
               recover = 1'b1;
            end
         end
         ST_OFF: begin
            if (!env_ok_s)     state_d = ST_WAIT;
            else if (off_done) state_d = ST_GRACE;
         end
         default: state_d = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_WAIT;
         tmr_q     <= '0;
         pwr_en_q  <= 1'b0;
         mem_sel_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         pwr_en_q  <= (state_d == ST_GRACE) || (state_d == ST_RUN);
         mem_sel_q <= mem_sel_q ^ recover;
         if (state_d != state_q)              tmr_q <= '0;
         else if (tick && tmr_q != TMR_TOP)   tmr_q <= tmr_q + 1'b1;
      end
   end

   prs_sat_count #(.W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (recover),
      .cnt_o (recov_cnt_o)
   );

   assign fpga_pwr_en_o = pwr_en_q;
   assign mem_sel_o     = mem_sel_q;
endmodule

// File: rtl/prs_sup_checker.sv
module prs_sup_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_en,
   input logic             mem_sel,
   input logic [CNT_W-1:0] cnt,
   input logic             env_ok
);
   AST_EN_NEEDS_ENV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> $past(env_ok)); // R1

   AST_ENV_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !env_ok |=> !pwr_en); // R9

   AST_SEL_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && $past(pwr_en)) |-> $stable(mem_sel)); // R6

   AST_SEL_FLIP_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwr_en) && $past(env_ok)) |-> (mem_sel != $past(mem_sel))); // R6

   AST_SEL_ONLY_AT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel != $past(mem_sel)) |-> $fell(pwr_en)); // R6

   AST_SEL_KEEP_ENV: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwr_en) && !$past(env_ok)) |-> ($stable(mem_sel) && $stable(cnt))); // R9

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R8

   AST_CNT_WITH_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_sel != $past(mem_sel)) && ($past(cnt) != '1)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R8
endmodule

bind pwr_recovery_sup prs_sup_checker #(.CNT_W(CNT_W)) u_sup_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pwr_en  (fpga_pwr_en_o),
   .mem_sel (mem_sel_o),
   .cnt     (recov_cnt_o),
   .env_ok  (env_ok_s)
);

// File: tb/pwr_recovery_sup_test.sv
module pwr_recovery_sup_test;
   localparam int G    = 20;
   localparam int T    = 30;
   localparam int OFFT = 16;
   localparam int CW   = 2;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          hb = 1'b0, req = 1'b0, pok = 1'b0, tok = 1'b0;
   logic          pwr_en, mem_sel;
   logic [CW-1:0] cnt;

   pwr_recovery_sup #(
      .GRACE_TICKS(G), .HB_TIMEOUT(T), .OFF_TICKS(OFFT),
      .TICK_DIV(1), .CNT_W(CW), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .hb_i(hb), .req_i(req),
      .pwr_ok_i(pok), .temp_ok_i(tok),
      .fpga_pwr_en_o(pwr_en), .mem_sel_o(mem_sel), .recov_cnt_o(cnt)
   );

   always #2 clk = ~clk;

   int checks = 0, errors = 0, ev_seen = 0, ncyc = 0, last_t = 0;
   bit hb_en = 1'b0;
   logic last_en = 1'b0;

   logic  q_en[$], q_mem[$];
   int    q_cnt[$], q_dur[$];
   string q_tag[$];

   task automatic push_exp(input logic en, input logic mem, input int c, input int dur, input string tag);
      q_en.push_back(en); q_mem.push_back(mem); q_cnt.push_back(c);
      q_dur.push_back(dur); q_tag.push_back(tag);
   endtask

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wait_ev(input int n);
      wait (ev_seen >= n);
   endtask

   // heartbeat source
   always begin
      repeat (5) @(negedge clk);
      if (hb_en) hb = ~hb;
   end

   // monitor: every change of the power enable is compared with the scoreboard
   always @(negedge clk) begin
      ncyc++;
      if (rst_n && pwr_en !== last_en) begin
         int dur;
         dur = ncyc - last_t;
         checks++;
         if (q_en.size() == 0) begin
            errors++;
            $display("FAIL R7 unexpected power change actual=%0b expected=none", pwr_en);
         end else begin
            logic e_en, e_mem;
            int e_cnt, e_dur;
            string tg;
            e_en = q_en.pop_front(); e_mem = q_mem.pop_front(); e_cnt = q_cnt.pop_front();
            e_dur = q_dur.pop_front(); tg = q_tag.pop_front();
            if (pwr_en !== e_en || mem_sel !== e_mem || int'(cnt) != e_cnt || (e_dur > 0 && dur != e_dur)) begin
               errors++;
               $display("FAIL %s event actual en=%0b sel=%0b cnt=%0d len=%0d expected en=%0b sel=%0b cnt=%0d len=%0d",
                        tg, pwr_en, mem_sel, cnt, dur, e_en, e_mem, e_cnt, e_dur);
            end
         end
         last_en = pwr_en;
         last_t  = ncyc;
         ev_seen++;
      end
   end

   initial begin
      repeat (20000) @(negedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic m;
      int ev;
      pok = 1'b1;
      tok = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pwr_en == 1'b0, "R2", "reset enable", pwr_en, 0);
      check(mem_sel == 1'b0, "R2", "reset select", mem_sel, 0);
      check(cnt == '0, "R2", "reset count", cnt, 0);

      repeat (50) @(negedge clk);
      check(pwr_en == 1'b0, "R1", "enable with temperature bad", pwr_en, 0);

      // R1: both healthy -> power up on primary copy
      hb_en = 1'b1;
      push_exp(1'b1, 1'b0, 0, 0, "R1");
      tok = 1'b1;
      wait_ev(1);
      repeat (150) @(negedge clk);

      // R7: long request level gives exactly one cycle
      push_exp(1'b0, 1'b1, 1, 0, "R7");
      push_exp(1'b1, 1'b1, 1, OFFT, "R5");
      req = 1'b1;
      repeat (40) @(negedge clk);
      req = 1'b0;
      wait_ev(3);
      repeat (150) @(negedge clk);

      // R4/R5/R8: heartbeat stops, repeated recoveries, counter saturates
      hb_en = 1'b0;
      push_exp(1'b0, 1'b0, 2, 0, "R4");
      push_exp(1'b1, 1'b0, 2, OFFT, "R5");
      push_exp(1'b0, 1'b1, 3, G + T, "R4");
      push_exp(1'b1, 1'b1, 3, OFFT, "R5");
      push_exp(1'b0, 1'b0, 3, G + T, "R8");
      push_exp(1'b1, 1'b0, 3, OFFT, "R8");
      wait_ev(9);

      // R6/R7: request swept around the heartbeat expiry cycle
      m  = 1'b0;
      ev = 9;
      for (int off = -3; off <= 3; off++) begin
         m = ~m;
         push_exp(1'b0, m, 3, 0, "R7");
         push_exp(1'b1, m, 3, OFFT, "R6");
         repeat (G + T - 3 + off) @(negedge clk);
         req = 1'b1;
         repeat (3) @(negedge clk);
         req = 1'b0;
         ev += 2;
         wait_ev(ev);
      end

      // R9: supply loss during grace, select and count untouched
      pok = 1'b0;
      push_exp(1'b0, m, 3, 0, "R9");
      wait_ev(ev + 1);
      repeat (40) @(negedge clk);
      check(pwr_en == 1'b0, "R9", "enable while supply bad", pwr_en, 0);
      hb_en = 1'b1;
      push_exp(1'b1, m, 3, 0, "R9");
      pok = 1'b1;
      wait_ev(ev + 2);

      // R3: live heartbeat keeps power on with no further events
      repeat (300) @(negedge clk);
      check(pwr_en == 1'b1, "R3", "enable with live heartbeat", pwr_en, 1);
      check(q_en.size() == 0, "R3", "pending expected events", q_en.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule